// File: doc/BRIEF.md
# Gated Traceback Output Stage for an 8-State Decoder

This block turns a complete frame of survivor decisions into the decoded bit sequence of a hard-decision trellis decoder. The code has constraint length 4, so the trellis has 8 states, and a frame is 24 stages long. The survivor storage supplies one decision bit per state per stage. When the frame is complete, the block walks the survivor path backward, from the last stage to the first, and starts from a chosen final state. The result is 24 decoded bits, delivered in the order in which the symbols were sent.

The backward walk is pure combinational logic. Its use is gated. Every decision bit, and the start state, passes through an AND array controlled by the end-of-frame strobe. Outside that one cycle, the walk therefore sees constant zeros and does not toggle while the storage is still filling. On the clock edge that ends the strobe cycle, the walk result is captured into an output register. A one-cycle valid pulse goes with the captured result. The register keeps its value until the next strobe.

Top module: `trace_out_gen`

## Requirements
- R1: While reset is asserted, and until the first strobe after reset, `out_bits`, `out_origin` and `out_valid` are all zero.
- R2: The state index is 3 bits. The predecessor of state s at stage k is `{s[1:0], d}`, where d is `dec_vec[(k-1)*8 + s]`. The decoded bit of stage k is `s[2]`, and it appears on `out_bits[k-1]`. So bit 0 is the first symbol of the frame.
- R3: The walk begins at stage 24 from the state on `start_state`. When a frame's encoder path ends in state 0 and the start state is 0, `out_bits` equals the transmitted message bits.
- R4: While `frame_end` is low, the gated decisions and the gated start state reaching the walk are all zero. The walk then produces all-zero bits and an origin of zero.
- R5: `out_valid` is high in exactly the cycle after each cycle in which `frame_end` was high at the clock edge, and in no other cycle.
- R6: While `frame_end` is low, `out_bits` and `out_origin` keep their last loaded values, whatever `dec_vec` and `start_state` do.
- R7: `frame_end` may be high on consecutive cycles. Each such cycle loads its own walk result, and `out_valid` stays high for the same number of cycles.
- R8: `out_origin` is the state reached after stepping back through stage 1. This is the path's starting state, which is 0 for an encoder that starts cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_end | input | 1 | End-of-frame strobe, high for the evaluation cycle |
| start_state | input | 3 | State from which the walk starts at the last stage |
| dec_vec | input | 192 | Decisions; bit (k-1)*8+s belongs to state s at stage k |
| out_bits | output | 24 | Decoded bits, bit 0 first in time |
| out_origin | output | 3 | State reached before stage 1 |
| out_valid | output | 1 | One-cycle pulse when a new result loads |

## Verification
The bench first checks that clean zero-terminated frames decode back to their messages. A design that reversed the output order, or took the decoded bit from the wrong end of the state, would return a scrambled message. It then checks walks from non-zero start states on random decisions, and an all-ones decision pattern. These catch a wrong predecessor shift or a slip in the stage-to-slice mapping. Between frames it scrambles the inputs and expects the output to stay frozen. This exposes a register that loads without the strobe or a gating array that lets inputs through. Back-to-back strobes expose a valid pulse that does not re-arm, or a load that is missed.

// File: rtl/trace_out_pkg.sv
package trace_out_pkg;
  // Trellis geometry shared by the traceback stage
  localparam int unsigned TRC_STATE_BITS = 3;
  localparam int unsigned TRC_STATES     = 1 << TRC_STATE_BITS;
  localparam int unsigned TRC_STAGES     = 24;

  typedef logic [TRC_STATE_BITS-1:0] trc_state_t;

  // Step one stage back: drop the newest input bit, shift in the decision
  function automatic trc_state_t trc_pred(input trc_state_t s, input logic d);
    return {s[TRC_STATE_BITS-2:0], d};
  endfunction
endpackage

// File: rtl/trace_gate_array.sv
module trace_gate_array #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             en,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_and
    assign d_out[i] = d_in[i] & en;
  end
endmodule

// File: rtl/trace_walk.sv
module trace_walk
  import trace_out_pkg::*;
#(
  parameter int unsigned STAGES = TRC_STAGES,
  localparam int unsigned NS    = TRC_STATES
) (
  input  logic [STAGES*NS-1:0] vecs,
  input  trc_state_t           start,
  output logic [STAGES-1:0]    bits,
  output trc_state_t           origin
);
  // st[k] is the path state at stage k; st[0] is the origin
  trc_state_t st [0:STAGES];

  assign st[STAGES] = start;
  assign origin     = st[0];

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    logic [NS-1:0] dv;
    assign dv        = vecs[(k-1)*NS +: NS];
    assign bits[k-1] = st[k][TRC_STATE_BITS-1];
    assign st[k-1]   = trc_pred(st[k], dv[st[k]]);
  end
endmodule

// File: rtl/trace_out_reg.sv
module trace_out_reg
  import trace_out_pkg::*;
#(
  parameter int unsigned STAGES = TRC_STAGES
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load,
  input  logic [STAGES-1:0] d_bits,
  input  trc_state_t        d_origin,
  output logic [STAGES-1:0] q_bits,
  output trc_state_t        q_origin,
  output logic              q_valid
);
  logic [STAGES-1:0] bits_nxt;
  trc_state_t        origin_nxt;

  always_comb begin
    bits_nxt   = q_bits;
    origin_nxt = q_origin;
    if (load) begin
      bits_nxt   = d_bits;
      origin_nxt = d_origin;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q_bits   <= '0;
      q_origin <= '0;
      q_valid  <= 1'b0;
    end else begin
      q_bits   <= bits_nxt;
      q_origin <= origin_nxt;
      q_valid  <= load;
    end
  end
endmodule

// File: rtl/trace_out_gen.sv
module trace_out_gen
  import trace_out_pkg::*;
#(
  parameter int unsigned STAGES = TRC_STAGES,
  localparam int unsigned NS    = TRC_STATES,
  localparam int unsigned SB    = TRC_STATE_BITS,
  localparam int unsigned VW    = STAGES * NS
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              frame_end,
  input  logic [SB-1:0]     start_state,
  input  logic [VW-1:0]     dec_vec,
  output logic [STAGES-1:0] out_bits,
  output logic [SB-1:0]     out_origin,
  output logic              out_valid
);
  // Reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  // Toggle filter: walk inputs are forced to zero outside the strobe
  logic [VW-1:0]     gated_vec;
  logic [SB-1:0]     gated_start;
  logic [STAGES-1:0] walk_bits;
  trc_state_t        walk_origin;

  trace_gate_array #(.WIDTH(VW)) u_gate_vec (
    .en(frame_end), .d_in(dec_vec), .d_out(gated_vec)
  );

  trace_gate_array #(.WIDTH(SB)) u_gate_start (
    .en(frame_end), .d_in(start_state), .d_out(gated_start)
  );

  trace_walk #(.STAGES(STAGES)) u_walk (
    .vecs(gated_vec), .start(gated_start),
    .bits(walk_bits), .origin(walk_origin)
  );

  trace_out_reg #(.STAGES(STAGES)) u_oreg (
    .clk(clk), .rst_ni(rst_n_sync), .load(frame_end),
    .d_bits(walk_bits), .d_origin(walk_origin),
    .q_bits(out_bits), .q_origin(out_origin), .q_valid(out_valid)
  );
endmodule

// File: rtl/trace_out_gen_chk.sv
module trace_out_gen_chk #(
  parameter int unsigned STAGES = 24,
  parameter int unsigned SB     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_end,
  input logic [SB-1:0]     start_state,
  input logic [STAGES-1:0] walk_bits,
  input logic [SB-1:0]     walk_origin,
  input logic [STAGES-1:0] out_bits,
  input logic [SB-1:0]     out_origin,
  input logic              out_valid
);
  AST_IDLE_WALK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |-> (walk_bits == '0 && walk_origin == '0)); // R4

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> out_valid); // R5

  AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> !out_valid); // R5

  AST_LOAD_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (out_bits == $past(walk_bits) && out_origin == $past(walk_origin))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(out_bits) && $stable(out_origin))); // R6

  AST_LAST_BIT_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> out_bits[STAGES-1] == $past(start_state[SB-1])); // R3
endmodule

bind trace_out_gen trace_out_gen_chk #(.STAGES(STAGES), .SB(SB)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .frame_end(frame_end),
  .start_state(start_state), .walk_bits(walk_bits), .walk_origin(walk_origin),
  .out_bits(out_bits), .out_origin(out_origin), .out_valid(out_valid)
);

// File: tb/trace_out_gen_tb.sv
module trace_out_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSTG = 24;
  localparam int NST  = 8;
  localparam int VW   = NSTG * NST;

  logic            clk;
  logic            rst_ni;
  logic            frame_end;
  logic [2:0]      start_state;
  logic [VW-1:0]   dec_vec;
  logic [NSTG-1:0] out_bits;
  logic [2:0]      out_origin;
  logic            out_valid;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  bit have_last = 0;
  logic [NSTG-1:0] last_bits;
  logic [2:0]      last_org;

  logic [NSTG-1:0] exp_bits_q [$];
  logic [2:0]      exp_org_q  [$];
  string           exp_tag_q  [$];

  trace_out_gen u_dut (
    .clk(clk), .rst_ni(rst_ni), .frame_end(frame_end),
    .start_state(start_state), .dec_vec(dec_vec),
    .out_bits(out_bits), .out_origin(out_origin), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // Walk following the predecessor rule of R2
  task automatic ref_walk(input logic [VW-1:0] v, input logic [2:0] st,
                          output logic [NSTG-1:0] b, output logic [2:0] org);
    logic [2:0] s;
    s = st;
    for (int k = NSTG; k >= 1; k--) begin
      b[k-1] = s[2];
      s = {s[1:0], v[(k-1)*NST + int'(s)]};
    end
    org = s;
  endtask

  // Encoder path for a 21-bit message plus 3 zero tail bits; decisions on the
  // true path point at the true predecessor, the rest are random
  task automatic clean_frame(output logic [VW-1:0] v, output logic [NSTG-1:0] msg);
    logic [2:0] s;
    logic [2:0] sp;
    v   = rand_vec();
    msg = '0;
    for (int i = 0; i < NSTG-3; i++) msg[i] = 1'($urandom);
    s = 3'd0;
    for (int k = 1; k <= NSTG; k++) begin
      sp = s;
      s  = {msg[k-1], sp[2:1]};
      v[(k-1)*NST + int'(s)] = sp[0];
    end
  endtask

  // Driver: present one strobe cycle, push expected result
  task automatic drive_strobe(input logic [VW-1:0] v, input logic [2:0] st,
                              input logic [NSTG-1:0] eb, input logic [2:0] eo, input string tag);
    @(negedge clk);
    dec_vec     = v;
    start_state = st;
    frame_end   = 1'b1;
    exp_bits_q.push_back(eb);
    exp_org_q.push_back(eo);
    exp_tag_q.push_back(tag);
  endtask

  task automatic idle_scramble(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_end   = 1'b0;
      dec_vec     = rand_vec();
      start_state = 3'($urandom);
    end
  endtask

  // Monitor: sample a quarter period after each rising edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_ni && !done) begin
      if (frame_end || out_valid)
        check(out_valid == frame_end, "R5 valid pulse", 32'(out_valid), 32'(frame_end));
      if (out_valid) begin
        if (exp_bits_q.size() == 0) begin
          check(1'b0, "R5 unexpected valid", 32'(out_valid), 32'd0);
        end else begin
          string tg;
          logic [NSTG-1:0] eb;
          logic [2:0] eo;
          eb = exp_bits_q.pop_front();
          eo = exp_org_q.pop_front();
          tg = exp_tag_q.pop_front();
          check(out_bits == eb, {tg, " bits"}, 32'(out_bits), 32'(eb));
          check(out_origin == eo, {"R8 origin ", tg}, 32'(out_origin), 32'(eo));
          last_bits = eb;
          last_org  = eo;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        check(out_bits == last_bits && out_origin == last_org, "R6 hold",
              32'(out_bits), 32'(last_bits));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [VW-1:0]   v;
    logic [NSTG-1:0] msg;
    logic [NSTG-1:0] eb;
    logic [2:0]      eo;
    logic [2:0]      st;
    rst_ni = 1'b0;
    frame_end = 1'b0;
    start_state = 3'd0;
    dec_vec = '0;
    repeat (3) @(negedge clk);
    check(out_bits == '0 && out_valid == 1'b0 && out_origin == '0, "R1 reset",
          32'(out_bits), 32'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    dec_vec = rand_vec();
    @(negedge clk);
    check(out_bits == '0 && out_valid == 1'b0 && out_origin == '0, "R1 after release",
          32'(out_bits), 32'd0);

    // R3: clean zero-terminated frames decode to the message
    for (int f = 0; f < 6; f++) begin
      clean_frame(v, msg);
      drive_strobe(v, 3'd0, msg, 3'd0, "R3 clean frame");
      idle_scramble(4);
    end

    // R2: random decisions from every start state
    for (int s = 0; s < 8; s++) begin
      v = rand_vec();
      st = 3'(s);
      ref_walk(v, st, eb, eo);
      drive_strobe(v, st, eb, eo, "R2 random walk");
      idle_scramble(3);
    end

    // R2: all-ones decisions from state 7 and all-zero from state 5
    v = '1;
    ref_walk(v, 3'd7, eb, eo);
    drive_strobe(v, 3'd7, eb, eo, "R2 all ones");
    idle_scramble(2);
    v = '0;
    ref_walk(v, 3'd5, eb, eo);
    drive_strobe(v, 3'd5, eb, eo, "R2 all zero");
    idle_scramble(2);

    // R7: back-to-back strobes, three in a row
    for (int b = 0; b < 3; b++) begin
      clean_frame(v, msg);
      drive_strobe(v, 3'd0, msg, 3'd0, "R7 back to back");
    end
    idle_scramble(6);

    // R4/R6: long scramble with strobe low, output must not move
    idle_scramble(20);
    @(negedge clk);
    check(exp_bits_q.size() == 0, "R7 all results seen", 32'(exp_bits_q.size()), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule